// File: doc/BRIEF.md
# Secured OTP Region Controller

This block sits behind the command decoder of a serial flash slave and owns a 512-byte one-time-programmable region. A bare "enter" command switches the slave into OTP mode, in which the block raises a flag that keeps the main array away from reads and programs, and serves those accesses from its own store instead. A bare "exit" command returns the slave to normal operation. The first 16 bytes of the region hold a factory serial number, which can never be programmed. The remaining 496 bytes belong to the customer. Programming there can only clear bits.

A security register reports whether the customer area has been locked and whether continuous-program mode is active. A bare "lock" command sets a sticky lock bit, after which the customer area can no longer be changed. The lock command needs the write-enable latch, and it asks the status logic to consume that latch when it takes effect. A read-security-register opcode captures a snapshot of the register for the front end to shift out.

Top module: `secured_otp_ctrl`

## Requirements
- R1: After reset, OTP mode is off (`main_block` = 0), the lock bit is clear, `rd_valid` and `wel_consume` are 0, and every customer byte holds FFh.
- R2: A frame whose first byte is the enter opcode (default B1h) and that ends exactly after that byte (`cs_done` with `cs_exact` = 1) sets `main_block` from the next cycle. The exit opcode (default C1h) clears it the same way. If the frame ends with `cs_exact` = 0, OTP mode does not change.
- R3: In OTP mode, `rd_req` returns the byte at offset `rd_addr` modulo 512 on `rd_data`, with `rd_valid` = 1, one cycle later. Outside OTP mode, `rd_req` never raises `rd_valid`.
- R4: Offsets 0 to 15 read as the serial number. Byte i equals (SEED + 37*i) mod 256, with SEED defaulting to 5Ah.
- R5: An unprogrammed customer offset (16 to 511) reads FFh.
- R6: In OTP mode, while the region is unlocked, `pg_req` at customer offset a replaces the stored byte with old AND `pg_data`. Outside OTP mode, `pg_req` leaves the region unchanged.
- R7: `pg_req` at offsets 0 to 15 never alters the serial number.
- R8: A frame with the lock opcode (default 2Fh) that ends with `cs_exact` = 1 while `wel` = 1 sets the lock bit and pulses `wel_consume` in the cycle `cs_done` is high. If `wel` is 0 or `cs_exact` is 0, the lock bit stays clear and `wel_consume` stays 0.
- R9: Once the lock bit is set, customer programs have no effect, and no later command clears the lock bit.
- R10: The read-security opcode (default 2Bh) on `op_valid` loads `scur_data` on the next cycle with bit0 = 1 (serial number locked), bit1 = lock bit, bit4 = `cp_mode`, and all other bits 0. `scur_data` holds its value between such strobes.
- R11: A frame end acts only on the opcode of the current frame. A `cs_done` with no new opcode since the previous `cs_done`, or a frame carrying any other opcode, changes neither the mode nor the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | First byte of a frame (the opcode) has been received |
| op_code | input | 8 | That opcode |
| cs_done | input | 1 | Chip select has returned high (frame end) |
| cs_exact | input | 1 | With cs_done: the frame was exactly one byte long |
| wel | input | 1 | Write-enable latch from the status logic |
| cp_mode | input | 1 | Continuous-program mode is active |
| rd_req | input | 1 | Read byte request |
| rd_addr | input | 24 | Read address |
| pg_req | input | 1 | Program byte request |
| pg_addr | input | 24 | Program address |
| pg_data | input | 8 | Program data |
| main_block | output | 1 | OTP mode active; main array access is blocked |
| wel_consume | output | 1 | Lock command taken; clear the write-enable latch |
| scur_data | output | 8 | Security register snapshot |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |

## Verification
The assertions assume that the front end never raises `op_valid` and `cs_done` in the same cycle. They also assume that `cs_exact` is only meaningful together with `cs_done`, and that read and program requests are single-cycle pulses. The stimulus drives each frame as an opcode cycle followed by a separate frame-end cycle. It pulses each request for exactly one cycle and changes inputs only on the falling clock edge, so every assumed ordering holds throughout the sweeps.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam int SCUR_FACT_BIT = 0;
  localparam int SCUR_LOCK_BIT = 1;
  localparam int SCUR_CP_BIT   = 4;

  // serial number byte at index idx
  function automatic logic [7:0] esn_byte(input logic [7:0] seed, input logic [8:0] idx);
    logic [15:0] prod;
    prod = 16'(idx) * 16'd37;
    return seed + prod[7:0];
  endfunction

  // one-time programming only clears bits
  function automatic logic [7:0] otp_merge(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  function automatic logic [7:0] scur_pack(input logic lock_b, input logic cp_b);
    logic [7:0] v;
    v = 8'h00;
    v[SCUR_FACT_BIT] = 1'b1;
    v[SCUR_LOCK_BIT] = lock_b;
    v[SCUR_CP_BIT]   = cp_b;
    return v;
  endfunction

endpackage

// File: rtl/otp_cmd_ctrl.sv
module otp_cmd_ctrl
  import otp_pkg::*;
#(
  parameter logic [7:0] OP_ENTER  = 8'hB1,
  parameter logic [7:0] OP_EXIT   = 8'hC1,
  parameter logic [7:0] OP_RDSCUR = 8'h2B,
  parameter logic [7:0] OP_WRSCUR = 8'h2F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [7:0] op_code,
  input  logic       cs_done,
  input  logic       cs_exact,
  input  logic       wel,
  input  logic       cp_mode,
  output logic       otp_mode,
  output logic       lock,
  output logic       wel_consume,
  output logic [7:0] scur_data
);

  logic       pend_q;
  logic [7:0] pend_op_q;
  logic       otp_mode_q;
  logic       lock_q;
  logic [7:0] scur_q;

  // named events
  logic bare_ok;
  logic do_enter;
  logic do_exit;
  logic do_lock;
  logic do_snap;

  assign bare_ok  = cs_done && cs_exact && pend_q;
  assign do_enter = bare_ok && (pend_op_q == OP_ENTER);
  assign do_exit  = bare_ok && (pend_op_q == OP_EXIT);
  assign do_lock  = bare_ok && (pend_op_q == OP_WRSCUR) && wel;
  assign do_snap  = op_valid && (op_code == OP_RDSCUR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      pend_op_q <= 8'h00;
    end else if (op_valid) begin
      pend_q    <= 1'b1;
      pend_op_q <= op_code;
    end else if (cs_done) begin
      pend_q    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      otp_mode_q <= 1'b0;
    end else if (do_enter) begin
      otp_mode_q <= 1'b1;
    end else if (do_exit) begin
      otp_mode_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (do_lock) begin
      lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scur_q <= 8'h00;
    end else if (do_snap) begin
      scur_q <= scur_pack(lock_q, cp_mode);
    end
  end

  assign otp_mode    = otp_mode_q;
  assign lock        = lock_q;
  assign wel_consume = do_lock;
  assign scur_data   = scur_q;

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  // R8
  lock_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(wel && cs_done && cs_exact));

  // R2
  mode_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(otp_mode_q) |-> $past(cs_done && cs_exact));

  // R11
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_done && !op_valid) |=> !pend_q);

endmodule

// File: rtl/otp_store.sv
module otp_store
  import otp_pkg::*;
#(
  parameter int         REGION_BYTES = 512,
  parameter int         ESN_BYTES    = 16,
  parameter logic [7:0] ESN_SEED     = 8'h5A,
  localparam int        OFF_W        = $clog2(REGION_BYTES),
  localparam int        CUST_BYTES   = REGION_BYTES - ESN_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             otp_mode,
  input  logic             lock,
  input  logic             rd_req,
  input  logic [OFF_W-1:0] rd_off,
  input  logic             pg_req,
  input  logic [OFF_W-1:0] pg_off,
  input  logic [7:0]       pg_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             wr_en
);

  localparam logic [OFF_W-1:0] ESN_OFF = OFF_W'(ESN_BYTES);

  logic [7:0]       cust_q [CUST_BYTES];
  logic [OFF_W-1:0] rd_idx;
  logic [OFF_W-1:0] wr_idx;
  logic [7:0]       rd_byte;
  logic [7:0]       old_byte;
  logic             rd_valid_q;
  logic [7:0]       rd_data_q;

  assign rd_idx   = rd_off - ESN_OFF;
  assign wr_idx   = pg_off - ESN_OFF;
  assign old_byte = cust_q[wr_idx];
  assign rd_byte  = (rd_off < ESN_OFF) ? esn_byte(ESN_SEED, 9'(rd_off)) : cust_q[rd_idx];
  assign wr_en    = pg_req && otp_mode && !lock && (pg_off >= ESN_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CUST_BYTES; i++) cust_q[i] <= 8'hFF;
    end else if (wr_en) begin
      cust_q[wr_idx] <= otp_merge(old_byte, pg_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= 8'h00;
    end else begin
      rd_valid_q <= rd_req && otp_mode;
      if (rd_req && otp_mode) rd_data_q <= rd_byte;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  // R6
  bits_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((cust_q[$past(wr_idx)] & ~$past(old_byte)) == 8'h00));

  // R3
  rd_in_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(otp_mode));

endmodule

// File: rtl/secured_otp_ctrl.sv
module secured_otp_ctrl
  import otp_pkg::*;
#(
  parameter int         ADDR_W       = 24,
  parameter int         REGION_BYTES = 512,
  parameter int         ESN_BYTES    = 16,
  parameter logic [7:0] ESN_SEED     = 8'h5A,
  parameter logic [7:0] OP_ENTER     = 8'hB1,
  parameter logic [7:0] OP_EXIT      = 8'hC1,
  parameter logic [7:0] OP_RDSCUR    = 8'h2B,
  parameter logic [7:0] OP_WRSCUR    = 8'h2F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [7:0]        op_code,
  input  logic              cs_done,
  input  logic              cs_exact,
  input  logic              wel,
  input  logic              cp_mode,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              pg_req,
  input  logic [ADDR_W-1:0] pg_addr,
  input  logic [7:0]        pg_data,
  output logic              main_block,
  output logic              wel_consume,
  output logic [7:0]        scur_data,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);

  localparam int OFF_W = $clog2(REGION_BYTES);

  logic mode_w;
  logic lock_w;
  logic store_wr;
  logic addr_hi_unused;

  assign addr_hi_unused = ^{rd_addr[ADDR_W-1:OFF_W], pg_addr[ADDR_W-1:OFF_W]};

  otp_cmd_ctrl #(
    .OP_ENTER (OP_ENTER),
    .OP_EXIT  (OP_EXIT),
    .OP_RDSCUR(OP_RDSCUR),
    .OP_WRSCUR(OP_WRSCUR)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .cs_done    (cs_done),
    .cs_exact   (cs_exact),
    .wel        (wel),
    .cp_mode    (cp_mode),
    .otp_mode   (mode_w),
    .lock       (lock_w),
    .wel_consume(wel_consume),
    .scur_data  (scur_data)
  );

  otp_store #(
    .REGION_BYTES(REGION_BYTES),
    .ESN_BYTES   (ESN_BYTES),
    .ESN_SEED    (ESN_SEED)
  ) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .otp_mode(mode_w),
    .lock    (lock_w),
    .rd_req  (rd_req),
    .rd_off  (rd_addr[OFF_W-1:0]),
    .pg_req  (pg_req),
    .pg_off  (pg_addr[OFF_W-1:0]),
    .pg_data (pg_data),
    .rd_valid(rd_valid),
    .rd_data (rd_data),
    .wr_en   (store_wr)
  );

  assign main_block = mode_w;

  // R6
  wr_in_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_wr |-> main_block);

  // R9
  no_wr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_wr |-> !lock_w);

  // R8
  consume_sets_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wel_consume |=> scur_data[SCUR_LOCK_BIT] || lock_w);

endmodule

// File: tb/secured_otp_ctrl_tb.sv
module secured_otp_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  op_code = 8'h00;
  logic        cs_done = 1'b0;
  logic        cs_exact = 1'b0;
  logic        wel = 1'b0;
  logic        cp_mode = 1'b0;
  logic        rd_req = 1'b0;
  logic [23:0] rd_addr = '0;
  logic        pg_req = 1'b0;
  logic [23:0] pg_addr = '0;
  logic [7:0]  pg_data = 8'h00;
  logic        main_block;
  logic        wel_consume;
  logic [7:0]  scur_data;
  logic        rd_valid;
  logic [7:0]  rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] model [512];

  always #5 clk = ~clk;

  secured_otp_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .cs_done(cs_done), .cs_exact(cs_exact), .wel(wel), .cp_mode(cp_mode),
    .rd_req(rd_req), .rd_addr(rd_addr), .pg_req(pg_req), .pg_addr(pg_addr),
    .pg_data(pg_data), .main_block(main_block), .wel_consume(wel_consume),
    .scur_data(scur_data), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [7:0] exp_esn(input int i);
    return 8'((90 + 37 * i) % 256);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [23:0] a, output logic v, output logic [7:0] d);
    @(negedge clk); rd_req = 1'b1; rd_addr = a;
    @(negedge clk); rd_req = 1'b0; v = rd_valid; d = rd_data;
  endtask

  task automatic do_prog(input logic [23:0] a, input logic [7:0] d);
    @(negedge clk); pg_req = 1'b1; pg_addr = a; pg_data = d;
    @(negedge clk); pg_req = 1'b0;
  endtask

  task automatic frame(input logic [7:0] op, input logic exact, output logic consumed);
    @(negedge clk); op_valid = 1'b1; op_code = op;
    @(negedge clk); op_valid = 1'b0; cs_done = 1'b1; cs_exact = exact;
    #1 consumed = wel_consume;
    @(negedge clk); cs_done = 1'b0; cs_exact = 1'b0;
  endtask

  task automatic rdscur(output logic [7:0] s);
    @(negedge clk); op_valid = 1'b1; op_code = 8'h2B;
    @(negedge clk); op_valid = 1'b0; s = scur_data;
    cs_done = 1'b1; cs_exact = 1'b0;
    @(negedge clk); cs_done = 1'b0;
  endtask

  task automatic sweep_all(input string req);
    logic v; logic [7:0] d;
    for (int a = 0; a < 512; a++) begin
      do_read(24'(a), v, d);
      check(req, {31'd0, v}, 32'd1);
      check(req, {24'd0, d}, {24'd0, model[a]});
    end
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic v; logic [7:0] d; logic c; logic [7:0] s;
    for (int a = 0; a < 512; a++) model[a] = (a < 16) ? exp_esn(a) : 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", {31'd0, main_block}, 32'd0);
    check("R1", {31'd0, rd_valid}, 32'd0);
    check("R1", {31'd0, wel_consume}, 32'd0);
    // R10 snapshot after reset
    rdscur(s);
    check("R10", {24'd0, s}, 32'h01);
    // R3 no read outside mode
    do_read(24'h20, v, d);
    check("R3", {31'd0, v}, 32'd0);
    // R2 inexact enter rejected, exact accepted
    frame(8'hB1, 1'b0, c);
    check("R2", {31'd0, main_block}, 32'd0);
    frame(8'hB1, 1'b1, c);
    check("R2", {31'd0, main_block}, 32'd1);
    // R4 R5 R1 full sweep after reset
    sweep_all("R4_R5");
    // R3 address wrap
    do_read(24'h012345, v, d);
    check("R3", {31'd0, v}, 32'd1);
    check("R3", {24'd0, d}, {24'd0, model[9'h145]});
    // R6 R7 program first pattern everywhere
    for (int a = 0; a < 512; a++) begin
      logic [7:0] p;
      p = 8'((a * 7) ^ 8'h3C);
      do_prog(24'(a), p);
      if (a >= 16) model[a] = model[a] & p;
    end
    sweep_all("R6_R7");
    // R6 second pattern only clears further
    for (int a = 0; a < 512; a++) begin
      logic [7:0] p;
      p = ~8'(a * 3);
      do_prog(24'(a) | 24'h400, p);
      if (a >= 16) model[a] = model[a] & p;
    end
    sweep_all("R6");
    // R2 exit, R6 program outside mode ignored
    frame(8'hC1, 1'b1, c);
    check("R2", {31'd0, main_block}, 32'd0);
    do_prog(24'd300, 8'h00);
    do_read(24'd300, v, d);
    check("R3", {31'd0, v}, 32'd0);
    frame(8'hB1, 1'b1, c);
    do_read(24'd300, v, d);
    check("R6", {24'd0, d}, {24'd0, model[300]});
    // R8 lock without WEL or inexact
    wel = 1'b0;
    frame(8'h2F, 1'b1, c);
    check("R8", {31'd0, c}, 32'd0);
    wel = 1'b1;
    frame(8'h2F, 1'b0, c);
    check("R8", {31'd0, c}, 32'd0);
    // R11 stale frame end without new opcode
    @(negedge clk); cs_done = 1'b1; cs_exact = 1'b1;
    #1 check("R11", {31'd0, wel_consume}, 32'd0);
    @(negedge clk); cs_done = 1'b0; cs_exact = 1'b0;
    // R11 unrelated opcode
    frame(8'h06, 1'b1, c);
    check("R11", {31'd0, c}, 32'd0);
    check("R11", {31'd0, main_block}, 32'd1);
    rdscur(s);
    check("R8", {24'd0, s}, 32'h01);
    // R8 proper lock
    frame(8'h2F, 1'b1, c);
    check("R8", {31'd0, c}, 32'd1);
    wel = 1'b0;
    rdscur(s);
    check("R10", {24'd0, s}, 32'h03);
    cp_mode = 1'b1;
    rdscur(s);
    check("R10", {24'd0, s}, 32'h13);
    @(negedge clk); cp_mode = 1'b0;
    @(negedge clk);
    check("R10", {24'd0, scur_data}, 32'h13);
    // R9 programs ignored after lock
    do_prog(24'd100, 8'h00);
    do_prog(24'd511, 8'h00);
    do_read(24'd100, v, d);
    check("R9", {24'd0, d}, {24'd0, model[100]});
    do_read(24'd511, v, d);
    check("R9", {24'd0, d}, {24'd0, model[511]});
    // R9 lock survives exit, enter and more commands
    frame(8'hC1, 1'b1, c);
    frame(8'hB1, 1'b1, c);
    frame(8'h2F, 1'b0, c);
    rdscur(s);
    check("R9", {24'd0, s}, 32'h03);
    // R7 serial number still intact
    do_prog(24'd3, 8'h00);
    do_read(24'd3, v, d);
    check("R7", {24'd0, d}, {24'd0, exp_esn(3)});
    done = 1;
    summary();
  end

endmodule